// File: doc/BRIEF.md
# Branch Trace Address Receiver

This block listens to a narrow debug trace port made of a trace clock, a framing line and four data lines, and rebuilds the 32-bit destination addresses of taken branches. When the framing line is high, each trace clock rising edge carries a command nibble. The command says how many address nibbles will follow: one, two, four or eight. When the framing line is low, the block places those nibbles into a working address, starting with the least significant nibble. Short transfers only refresh the low part of the address. The upper bits are taken from the last address the block reported, so a compressed stream expands to full addresses.

A transfer is closed by the next high-framing nibble. A fresh command can close one transfer and open the next in the same edge. At that point the rebuilt address is driven on a 32-bit output with a one-cycle valid strobe. The trace port is asynchronous to the system clock. All four data lines, the framing line and the trace clock pass through flop synchronizers. The system clock has to run several times faster than the trace clock.

Top module: `brt_rx`

## Requirements
- R1: Data and framing are captured only on rising edges of the trace clock. Level changes while the trace clock is steady, and falling edges, have no effect.
- R2: A nibble is formed with data line 3 as bit 3 and data line 0 as bit 0, so data value 4'b1000 written at nibble 0 sets address bit 3 only.
- R3: With framing high, command 4'h8 announces 1 nibble, 4'h9 announces 2, 4'hA announces 4 and 4'hB announces 8.
- R4: Any other command value with framing high (idle 4'h3 included) announces nothing. Data nibbles that follow it neither change the address nor produce a report.
- R5: With framing low and a transfer open, the k-th data nibble (k from 0) replaces address bits [4k+3:4k] and leaves all other bits untouched.
- R6: A transfer of n < 8 nibbles reports an address whose bits above 4n equal those of the previously reported address.
- R7: A report is made only when a high-framing nibble arrives after exactly the announced number of nibbles. `addr_valid_o` is then high for one system clock, and `addr_o` holds the value until the next report.
- R8: A transfer closed early by a high-framing nibble produces no report. Its nibbles do not reach later addresses, which merge with the last reported address instead.
- R9: Data nibbles past the announced count pulse `overrun_o` for one cycle each and are not written into the address.
- R10: After reset `addr_valid_o` is 0, `addr_o` is 0 and the merge base is 0, so a first one-nibble transfer of value v reports v.
- R11: A valid command that closes a complete transfer reports it and opens the next transfer in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the trace clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tck_i | input | 1 | Trace clock, asynchronous |
| tsync_n_i | input | 1 | Framing: high = command phase, low = address nibbles |
| tdata_i | input | 4 | Trace data lines, bit 3 most significant |
| addr_valid_o | output | 1 | One-cycle strobe for a completed address |
| addr_o | output | 32 | Last completed branch destination address |
| overrun_o | output | 1 | One-cycle strobe for a nibble beyond the announced count |

## Verification
The bound checker watches the following on every cycle:
- the report strobe is one cycle wide and never coincides with an overrun;
- a report follows only a captured high-framing edge, and the reported value equals the stored merge base;
- the merge base changes only on a report;
- the nibble count never passes the announced length;
- nothing moves between trace clock rising edges or while no transfer is open.

The bench's scenarios are needed for the rest:
- the arithmetic of merging and nibble placement;
- the decoding of each command value;
- bit order on the data lines;
- the handling of truncated and over-long transfers;
- immunity to glitches on falling edges.

The bench runs these over a sweep of every transfer length against many address values.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int unsigned NIB_W = 4;

  // announced nibble count for a command, 0 for idle or unknown
  function automatic int unsigned cmd_len(input logic [NIB_W-1:0] cmd);
    case (cmd)
      4'h8:    return 1;
      4'h9:    return 2;
      4'hA:    return 4;
      4'hB:    return 8;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/brt_sync.sv
module brt_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/brt_edge.sv
module brt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d_q <= 1'b0;
    else         lvl_d_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_d_q;
endmodule

// File: rtl/brt_assembler.sv
module brt_assembler
  import brt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned NIBS  = ADDR_W / NIB_W,
  localparam int unsigned CNT_W = $clog2(NIBS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              cmd_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              overrun_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  len_o,
  output logic [ADDR_W-1:0] work_o,
  output logic [ADDR_W-1:0] last_o
);
  logic [CNT_W-1:0]  cnt_q, len_q, len_d;
  logic [ADDR_W-1:0] work_q, last_q, addr_q, merged;
  logic              valid_q, ovr_q, done, wr;

  assign len_d = CNT_W'(cmd_len(nib_i));
  assign done  = (len_q != '0) && (cnt_q == len_q);
  assign wr    = !cmd_i && (len_q != '0) && (cnt_q < len_q);

  // replace only the addressed nibble
  always_comb begin
    merged = work_q;
    for (int k = 0; k < int'(NIBS); k++) begin
      if (cnt_q == CNT_W'(k)) merged[k*NIB_W +: NIB_W] = nib_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      len_q   <= '0;
      work_q  <= '0;
      last_q  <= '0;
      addr_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      if (rise_i) begin
        if (cmd_i) begin
          if (done) begin
            valid_q <= 1'b1;
            addr_q  <= work_q;
            last_q  <= work_q;
          end else begin
            work_q  <= last_q;
          end
          cnt_q <= '0;
          len_q <= len_d;
        end else if (wr) begin
          work_q <= merged;
          cnt_q  <= cnt_q + 1'b1;
        end else if (len_q != '0) begin
          ovr_q <= 1'b1;
        end
      end
    end
  end

  assign valid_o   = valid_q;
  assign addr_o    = addr_q;
  assign overrun_o = ovr_q;
  assign cnt_o     = cnt_q;
  assign len_o     = len_q;
  assign work_o    = work_q;
  assign last_o    = last_q;
endmodule

// File: rtl/brt_rx.sv
module brt_rx
  import brt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NIBS       = ADDR_W / NIB_W,
  localparam int unsigned CNT_W      = $clog2(NIBS + 1),
  localparam int unsigned IN_W       = NIB_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tck_i,
  input  logic              tsync_n_i,
  input  logic [3:0]        tdata_i,
  output logic              addr_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              overrun_o
);
  logic [IN_W-1:0]   in_s;
  logic              tck_s, smp_cmd, rise;
  logic [NIB_W-1:0]  smp_nib;
  logic [CNT_W-1:0]  cnt, len;
  logic [ADDR_W-1:0] work, last;

  // all lines share one synchronizer so they stay aligned
  brt_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({tck_i, tsync_n_i, tdata_i}),
    .q_o    (in_s)
  );

  assign tck_s   = in_s[IN_W-1];
  assign smp_cmd = in_s[NIB_W];
  assign smp_nib = in_s[NIB_W-1:0];

  brt_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (tck_s),
    .rise_o (rise)
  );

  brt_assembler #(.ADDR_W(ADDR_W)) u_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .cmd_i     (smp_cmd),
    .nib_i     (smp_nib),
    .valid_o   (addr_valid_o),
    .addr_o    (addr_o),
    .overrun_o (overrun_o),
    .cnt_o     (cnt),
    .len_o     (len),
    .work_o    (work),
    .last_o    (last)
  );
endmodule

module brt_rx_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_valid_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              overrun_o,
  input logic              rise,
  input logic              smp_cmd,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  len,
  input logic [ADDR_W-1:0] work,
  input logic [ADDR_W-1:0] last
);
  assert_no_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> ($stable(work) && $stable(cnt) && !addr_valid_o && !overrun_o));

  assert_idle_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !smp_cmd && len == '0) |=> ($stable(work) && !addr_valid_o));

  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |=> !addr_valid_o);

  assert_report_on_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> $past(rise && smp_cmd));

  assert_report_is_base_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> addr_o == last);

  assert_base_only_on_report_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(last) |-> addr_valid_o);

  assert_cnt_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= len);

  assert_no_write_overrun_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> ($stable(work) && !addr_valid_o));
endmodule

bind brt_rx brt_rx_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_valid_o (addr_valid_o),
  .addr_o       (addr_o),
  .overrun_o    (overrun_o),
  .rise         (rise),
  .smp_cmd      (smp_cmd),
  .cnt          (cnt),
  .len          (len),
  .work         (work),
  .last         (last)
);

// File: tb/brt_rx_bench.sv
module brt_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tck = 1'b0;
  logic        tsync_n = 1'b1;
  logic [3:0]  tdata = 4'h3;
  logic        valid, ovr;
  logic [31:0] addr;

  int          n_chk = 0, n_err = 0;
  int          rep_n = 0, seen = 0, ovr_n = 0;
  logic [31:0] rep_addr [0:255];
  logic [31:0] prev = '0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  brt_rx u_brt_rx (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tck_i        (tck),
    .tsync_n_i    (tsync_n),
    .tdata_i      (tdata),
    .addr_valid_o (valid),
    .addr_o       (addr),
    .overrun_o    (ovr)
  );

  always @(negedge clk) begin
    if (valid) begin
      rep_addr[rep_n[7:0]] = addr;
      rep_n++;
    end
    if (ovr) ovr_n++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one trace clock period; garbage is driven around the falling edge
  task automatic tnib(input logic s, input logic [3:0] n);
    tck = 1'b0; tsync_n = ~s; tdata = ~n;
    repeat (2) @(negedge clk);
    tsync_n = s; tdata = n;
    repeat (2) @(negedge clk);
    tck = 1'b1;
    repeat (2) @(negedge clk);
    tsync_n = ~s; tdata = ~n;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [3:0] code(input int n);
    case (n)
      1: return 4'h8;
      2: return 4'h9;
      4: return 4'hA;
      default: return 4'hB;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] base, input logic [31:0] v, input int n);
    logic [63:0] m;
    m = (64'd1 << (4 * n)) - 64'd1;
    return (base & ~m[31:0]) | (v & m[31:0]);
  endfunction

  task automatic send(input int n, input logic [31:0] v);
    tnib(1'b1, code(n));
    for (int k = 0; k < n; k++) tnib(1'b0, v[4*k +: 4]);
  endtask

  task automatic close();
    tnib(1'b1, 4'h3);
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_rep(input logic [31:0] exp, input string req);
    chk(rep_n == seen + 1, req, 32'(rep_n - seen), 32'd1);
    if (rep_n == seen + 1) chk(rep_addr[seen[7:0]] == exp, req, rep_addr[seen[7:0]], exp);
    seen = rep_n;
    prev = exp;
  endtask

  task automatic expect_none(input string req);
    chk(rep_n == seen, req, 32'(rep_n - seen), 32'd0);
    seen = rep_n;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(valid == 1'b0, "R10 valid", 32'(valid), 32'd0);
    chk(addr == 32'd0, "R10 addr", addr, 32'd0);

    // R10: first short transfer merges with zero
    send(1, 32'h5); close();
    expect_rep(32'h0000_0005, "R10");

    // R2: bit order
    send(1, 32'h8); close();
    expect_rep(merge(prev, 32'h8, 1), "R2");
    chk(addr[3:0] == 4'b1000, "R2 bits", 32'(addr[3:0]), 32'h8);

    // R3 R5 R6: sweep every length over many values
    for (int li = 0; li < 4; li++) begin
      for (int j = 0; j < 8; j++) begin
        int n;
        logic [31:0] v;
        n = 1 << li;
        v = 32'(j + 1) * 32'h9E37_79B1 + 32'h0123_4567 * 32'(li);
        send(n, v); close();
        if (n == 8) expect_rep(v, "R3 R5 full");
        else expect_rep(merge(prev, v, n), "R3 R6 merge");
      end
    end

    // R4: unknown command then data: ignored
    tnib(1'b1, 4'h5);
    for (int k = 0; k < 4; k++) tnib(1'b0, 4'(k + 9));
    close();
    expect_none("R4 unknown");
    tnib(1'b1, 4'h3);
    tnib(1'b0, 4'hE); tnib(1'b0, 4'hD);
    close();
    expect_none("R4 idle");
    chk(addr == prev, "R4 addr held", addr, prev);
    send(1, 32'h2); close();
    expect_rep(merge(prev, 32'h2, 1), "R4 base kept");

    // R8: truncated transfer
    tnib(1'b1, 4'hB);
    tnib(1'b0, 4'hA); tnib(1'b0, 4'hB); tnib(1'b0, 4'hC);
    close();
    expect_none("R8 truncated");
    send(1, 32'h7); close();
    expect_rep(merge(prev, 32'h7, 1), "R8 base");

    // R9: overrun
    ovr_n = 0;
    tnib(1'b1, 4'h8);
    tnib(1'b0, 4'h4); tnib(1'b0, 4'h6); tnib(1'b0, 4'h9);
    close();
    chk(ovr_n == 2, "R9 count", 32'(ovr_n), 32'd2);
    expect_rep(merge(prev, 32'h4, 1), "R9 addr");

    // R11: back-to-back transfers
    send(2, 32'h0000_00C3);
    send(4, 32'h0000_F1E2);
    repeat (4) @(negedge clk);
    expect_rep(merge(prev, 32'hC3, 2), "R11 first");
    close();
    expect_rep(merge(prev, 32'hF1E2, 4), "R11 second");

    // R1: trace clock held steady while lines toggle
    tck = 1'b1;
    for (int k = 0; k < 20; k++) begin
      tsync_n = k[0]; tdata = 4'(k * 5);
      @(negedge clk);
    end
    tck = 1'b0;
    for (int k = 0; k < 20; k++) begin
      tsync_n = k[1]; tdata = 4'(k * 3);
      @(negedge clk);
    end
    close();
    expect_none("R1 no edge");
    chk(addr == prev, "R1 addr held", addr, prev);
    send(1, 32'h1); close();
    expect_rep(merge(prev, 32'h1, 1), "R1 after");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule